// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital side of a 10-bit successive-approximation analog-to-digital converter. It sits behind a byte-wide register port with four locations: two control bytes and two result bytes. Software enables the converter, picks an input channel and a conversion clock, then writes a start bit. The block latches its setup and runs a binary search. It presents one trial code per conversion-clock period to an external DAC and keeps or drops each trial bit according to a comparator input. Three settling periods follow the last trial. The block then stores the 10-bit code, clears the start/busy bit and raises a sticky completion flag.

The conversion clock is the system clock divided by 2, 8 or 32. A fourth option uses a free-running tick from a separate RC oscillator. On that source the search begins only after a short fixed delay, and it survives a low-power sleep request. On any other source, sleep cancels the conversion and switches the converter off. The result is read as a high and a low byte. The bytes are justified left or right according to a format bit, and the format is applied when the bytes are read.

Top module: `adc_sar_ctrl`

## Requirements
- R1: After reset, all four register locations read 0x00 and `irq` is low.
- R2: Address 0 holds clock select in bits [7:6] (00 = /2, 01 = /8, 10 = /32, 11 = RC tick), channel in bits [5:3], start/busy in bit 2, a bit 1 that always reads 0, and enable in bit 0. Address 1 holds the format bit in bit 7, interrupt enable in bit 1 and the completion flag in bit 0. Address 2 is the result high byte and address 3 the result low byte.
- R3: Writing address 0 with bit 2 set starts a conversion when the enable bit was already 1 and no conversion is running. Bit 2 then reads 1 until hardware clears it at the end of the conversion.
- R4: With a divided clock of ratio D, bit 2 reads 0 again exactly 13·D system clocks after the clock edge that accepted the start. The 13 periods are 10 bit trials and 3 settling periods.
- R5: Trials run MSB first. The first code on `dac_code` is 0x200. A trial bit is kept when `cmp_in` is high at the end of its period, so an ideal comparator (input ≥ code) yields the input value.
- R6: While enable is 0, a start write is ignored. Clearing enable during a conversion cancels it on the following clock edge.
- R7: If `sleep_req` is high during a conversion on a divided clock, the conversion is cancelled at that edge and enable reads 0 afterwards. On the RC source the conversion completes and enable stays 1.
- R8: A cancelled conversion leaves both result bytes and the completion flag unchanged.
- R9: On the RC source, `dac_code` stays 0 for the first 4 system clocks after the start edge. Each later conversion period lasts one `rc_tick` pulse.
- R10: `chan_sel` shows the channel latched at the start, and that channel's comparator decision forms the result.
- R11: During a conversion, a write of 1 or 0 to bit 2 does not restart, stop or lengthen it. Changes to the channel or clock fields do not affect the conversion already running.
- R12: With format bit 1, high = {000000, res[9:8]} and low = res[7:0]. With format bit 0, high = res[9:2] and low = {res[1:0], 000000}. The format applies at read time.
- R13: Completion sets the flag. A write to address 1 with bit 0 = 0 clears it, and a write with bit 0 = 1 leaves it as it was. `irq` = flag AND interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| sleep_req | input | 1 | Low-power sleep request |
| rc_tick | input | 1 | One-cycle pulse from the RC conversion oscillator |
| cmp_in | input | 1 | Comparator decision: analog input ≥ DAC code |
| dac_code | output | 10 | Trial code driven to the DAC |
| chan_sel | output | 3 | Analog channel for the running conversion |
| irq | output | 1 | Completion interrupt |

## Verification
The bench times each divided-clock conversion to the exact cycle. A divider that is off by one, or a sequencer with too many or too few settling periods, would show up as a wrong 13·D count. It rewrites the control byte in the middle of a conversion. A design that sampled the fields live would switch channel or rate partway through, and one that honoured the second start would restart the search. It cancels conversions both by clearing enable and by sleep on a divided clock. A design that wrote partial results or raised the flag on cancel would corrupt the stored result. Under the RC source it checks the startup delay, and that sleep does not stop the conversion. A wrong format mux would swap or misalign the bytes.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;
  localparam int RES_W       = 10;
  localparam int BYTE_W      = 8;
  localparam int CH_W        = 3;
  localparam int SEL_W       = 2;
  localparam int ADDR_W      = 2;
  localparam int BIT_IDX_W   = $clog2(RES_W);
  localparam int SETTLE_TADS = 3;
  localparam int DIV_MAX     = 32;
  localparam int DIV_CNT_W   = $clog2(DIV_MAX);
  localparam int PAD_W       = 2 * BYTE_W - RES_W;

  typedef enum logic [SEL_W-1:0] {
    CLK_DIV2  = 2'b00,
    CLK_DIV8  = 2'b01,
    CLK_DIV32 = 2'b10,
    CLK_RC    = 2'b11
  } clk_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_TRIAL,
    ST_SETTLE
  } conv_st_e;

  localparam logic [ADDR_W-1:0] ADDR_CTRL0  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL1  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_RES_HI = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_RES_LO = 2'd3;

  // terminal count of the divider for a given clock option
  function automatic logic [DIV_CNT_W-1:0] div_last(clk_sel_e sel);
    case (sel)
      CLK_DIV2: div_last = DIV_CNT_W'(1);
      CLK_DIV8: div_last = DIV_CNT_W'(7);
      default:  div_last = DIV_CNT_W'(DIV_MAX - 1);
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] res_hi(logic [RES_W-1:0] r, logic right);
    if (right) res_hi = BYTE_W'(r >> BYTE_W);
    else       res_hi = r[RES_W-1 -: BYTE_W];
  endfunction

  function automatic logic [BYTE_W-1:0] res_lo(logic [RES_W-1:0] r, logic right);
    if (right) res_lo = r[BYTE_W-1:0];
    else       res_lo = {r[RES_W-BYTE_W-1:0], {PAD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/adc_sar_tad_gen.sv
module adc_sar_tad_gen
  import adc_sar_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  clk_sel_e sel,
  input  logic     rc_tick,
  output logic     tad_tick
);
  logic [DIV_CNT_W-1:0] cnt_q;
  logic                 term;
  logic                 use_rc;

  assign use_rc   = (sel == CLK_RC);
  assign term     = (cnt_q == div_last(sel));
  assign tad_tick = run && (use_rc ? rc_tick : term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!run || use_rc)  cnt_q <= '0;
    else if (term)            cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run && !use_rc |-> cnt_q <= div_last(sel)); // R4
endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine
  import adc_sar_pkg::*;
#(
  parameter int WAIT_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  clk_sel_e         sel_in,
  input  logic [CH_W-1:0]  ch_in,
  input  logic             tad_tick,
  input  logic             cmp_in,
  output clk_sel_e         sel_q,
  output logic [CH_W-1:0]  ch_q,
  output logic             run,
  output logic             busy,
  output logic             conv_done,
  output logic [RES_W-1:0] sar_q,
  output logic [RES_W-1:0] dac_code
);
  localparam int WAIT_W = $clog2(WAIT_CYC + 1);
  localparam int SET_W  = $clog2(SETTLE_TADS + 1);

  conv_st_e             st_q;
  logic [BIT_IDX_W-1:0] idx_q;
  logic [WAIT_W-1:0]    wait_q;
  logic [SET_W-1:0]     set_q;
  logic [RES_W-1:0]     trial_bit;
  logic                 last_trial;
  logic                 wait_over;

  for (genvar g = 0; g < RES_W; g++) begin : g_trial
    assign trial_bit[g] = (st_q == ST_TRIAL) && (idx_q == BIT_IDX_W'(g));
  end

  assign dac_code   = sar_q | trial_bit;
  assign run        = (st_q == ST_TRIAL) || (st_q == ST_SETTLE);
  assign busy       = (st_q != ST_IDLE);
  assign last_trial = (idx_q == '0);
  assign wait_over  = (wait_q == WAIT_W'(WAIT_CYC - 1));
  assign conv_done  = (st_q == ST_SETTLE) && tad_tick &&
                      (set_q == SET_W'(SETTLE_TADS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      wait_q <= '0;
      set_q  <= '0;
      sar_q  <= '0;
      sel_q  <= CLK_DIV2;
      ch_q   <= '0;
    end else if (abort) begin
      st_q <= ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          sel_q  <= sel_in;
          ch_q   <= ch_in;
          sar_q  <= '0;
          idx_q  <= BIT_IDX_W'(RES_W - 1);
          set_q  <= '0;
          wait_q <= '0;
          st_q   <= (sel_in == CLK_RC) ? ST_WAIT : ST_TRIAL;
        end
        ST_WAIT: begin
          if (wait_over) st_q <= ST_TRIAL;
          else           wait_q <= wait_q + 1'b1;
        end
        ST_TRIAL: if (tad_tick) begin
          if (cmp_in) sar_q <= sar_q | trial_bit;
          if (last_trial) st_q <= ST_SETTLE;
          else            idx_q <= idx_q - 1'b1;
        end
        ST_SETTLE: if (tad_tick) begin
          if (conv_done) st_q <= ST_IDLE;
          else           set_q <= set_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_END_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(conv_done || abort)); // R3

  AST_RC_DELAY_NO_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_WAIT |-> dac_code == '0); // R9

  AST_SETUP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(ch_q) && $stable(sel_q)); // R11
endmodule

// File: rtl/adc_sar_regs.sv
module adc_sar_regs
  import adc_sar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              busy,
  input  logic              conv_done,
  input  logic              abort,
  input  logic              sleep_kill,
  input  logic [RES_W-1:0]  sar_q,
  output logic [BYTE_W-1:0] rdata,
  output logic              start_req,
  output logic              en_q,
  output logic [SEL_W-1:0]  sel_fld,
  output logic [CH_W-1:0]   ch_fld,
  output logic              irq
);
  logic             just_q;
  logic             ie_q;
  logic             flag_q;
  logic [RES_W-1:0] res_q;
  logic             wr0;
  logic             wr1;
  logic             flag_clr;

  assign wr0       = wr_en && (addr == ADDR_CTRL0);
  assign wr1       = wr_en && (addr == ADDR_CTRL1);
  assign flag_clr  = wr1 && !wdata[0];
  assign start_req = wr0 && wdata[2] && en_q && !busy;
  assign irq       = flag_q && ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_fld <= '0;
      ch_fld  <= '0;
      en_q    <= 1'b0;
    end else begin
      if (wr0) begin
        sel_fld <= wdata[7:6];
        ch_fld  <= wdata[5:3];
        en_q    <= wdata[0];
      end
      if (sleep_kill) en_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      just_q <= 1'b0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      res_q  <= '0;
    end else begin
      if (wr1) begin
        just_q <= wdata[7];
        ie_q   <= wdata[1];
      end
      if (conv_done)     flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      if (conv_done) res_q <= sar_q;
    end
  end

  always_comb begin
    case (addr)
      ADDR_CTRL0:  rdata = {sel_fld, ch_fld, busy, 1'b0, en_q};
      ADDR_CTRL1:  rdata = {just_q, 5'b0, ie_q, flag_q};
      ADDR_RES_HI: rdata = res_hi(res_q, just_q);
      default:     rdata = res_lo(res_q, just_q);
    endcase
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !flag_clr |=> flag_q); // R13

  AST_CANCEL_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    abort && !wr_en |=> $stable(res_q) && $stable(flag_q)); // R8

  AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en_q)); // R6

  AST_SLEEP_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_kill |=> !en_q && !busy); // R7
endmodule

// File: rtl/adc_sar_ctrl.sv
module adc_sar_ctrl
  import adc_sar_pkg::*;
#(
  parameter int RC_WAIT_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              sleep_req,
  input  logic              rc_tick,
  input  logic              cmp_in,
  output logic [9:0]        dac_code,
  output logic [2:0]        chan_sel,
  output logic              irq
);
  logic             start_req;
  logic             en_q;
  logic [SEL_W-1:0] sel_fld;
  logic [CH_W-1:0]  ch_fld;
  clk_sel_e         sel_q;
  logic             run;
  logic             busy;
  logic             conv_done;
  logic             tad_tick;
  logic             sleep_kill;
  logic             abort;
  logic [RES_W-1:0] sar_q;

  assign sleep_kill = sleep_req && busy && (sel_q != CLK_RC);
  assign abort      = busy && (!en_q || sleep_kill);

  adc_sar_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_wr),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .busy       (busy),
    .conv_done  (conv_done),
    .abort      (abort),
    .sleep_kill (sleep_kill),
    .sar_q      (sar_q),
    .rdata      (bus_rdata),
    .start_req  (start_req),
    .en_q       (en_q),
    .sel_fld    (sel_fld),
    .ch_fld     (ch_fld),
    .irq        (irq)
  );

  adc_sar_engine #(.WAIT_CYC(RC_WAIT_CYC)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_req),
    .abort     (abort),
    .sel_in    (clk_sel_e'(sel_fld)),
    .ch_in     (ch_fld),
    .tad_tick  (tad_tick),
    .cmp_in    (cmp_in),
    .sel_q     (sel_q),
    .ch_q      (chan_sel),
    .run       (run),
    .busy      (busy),
    .conv_done (conv_done),
    .sar_q     (sar_q),
    .dac_code  (dac_code)
  );

  adc_sar_tad_gen u_tad (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .sel      (sel_q),
    .rc_tick  (rc_tick),
    .tad_tick (tad_tick)
  );
endmodule

// File: tb/tb_adc_sar_ctrl.sv
module tb_adc_sar_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {clock select, channel, right-justify, analog value}
  localparam logic [15:0] VEC [NVEC] = '{
    {2'd0, 3'd0, 1'b0, 10'h3FF},
    {2'd1, 3'd3, 1'b1, 10'h000},
    {2'd2, 3'd7, 1'b0, 10'h2A5},
    {2'd0, 3'd5, 1'b1, 10'h155},
    {2'd1, 3'd1, 1'b0, 10'h200},
    {2'd0, 3'd6, 1'b1, 10'h1FF}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       sleep_req = 1'b0;
  logic       rc_tick = 1'b0;
  logic       rc_on = 1'b0;
  logic       cmp_in;
  logic [9:0] dac_code;
  logic [2:0] chan_sel;
  logic       irq;
  logic [9:0] ana [8];
  int         cyc = 0;
  int         rc_cnt = 0;
  int         n_chk = 0;
  int         n_fail = 0;

  adc_sar_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_req(sleep_req),
    .rc_tick(rc_tick), .cmp_in(cmp_in), .dac_code(dac_code),
    .chan_sel(chan_sel), .irq(irq)
  );

  assign cmp_in = (ana[chan_sel] >= dac_code);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;
  always @(negedge clk) begin
    if (rc_on) begin
      rc_cnt  = (rc_cnt == 5) ? 0 : rc_cnt + 1;
      rc_tick = (rc_cnt == 0);
    end else begin
      rc_tick = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_addr = 2'd0;
  endtask

  function automatic logic [7:0] c0(input int sel, input int ch, input bit go, input bit en);
    c0 = {2'(sel), 3'(ch), go, 1'b0, en};
  endfunction

  // waits until busy reads 0; returns cycles since the start edge
  task automatic wait_idle(input int c_start, output int delta);
    logic [7:0] v;
    rd(2'd0, v);
    for (int i = 0; i < 3000 && v[2]; i++) begin
      @(negedge clk);
      rd(2'd0, v);
    end
    delta = cyc - c_start;
  endtask

  function automatic int exp_hi(input int v, input bit right);
    exp_hi = right ? v / 256 : v / 4;
  endfunction
  function automatic int exp_lo(input int v, input bit right);
    exp_lo = right ? v % 256 : (v % 4) * 64;
  endfunction
  function automatic int ratio(input int sel);
    ratio = (sel == 0) ? 2 : (sel == 1) ? 8 : 32;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, h, l, h2, l2;
    int d, cs;
    for (int i = 0; i < 8; i++) ana[i] = 10'(i * 91 + 13);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check(v == 8'h00, "R1 reset register", v, 0);
    end
    check(irq == 1'b0, "R1 reset irq", irq, 0);

    // R2 layout and R6 start ignored while disabled
    wr(2'd0, 8'hFF);
    repeat (4) @(negedge clk);
    rd(2'd0, v);
    check(v == 8'hF9, "R2/R6 ctrl0 readback, no start when off", v, 8'hF9);
    wr(2'd0, c0(0, 0, 0, 1));
    repeat (3) @(negedge clk);
    rd(2'd0, v);
    check(v[2] == 1'b0, "R11 write of 0 to start bit while idle", v[2], 0);

    // table of conversions: R3 R4 R5 R10 R12 R13
    for (int k = 0; k < NVEC; k++) begin
      int sel, ch, vin;
      bit rj;
      sel = int'(VEC[k][15:14]); ch = int'(VEC[k][13:11]);
      rj = VEC[k][10]; vin = int'(VEC[k][9:0]);
      ana[ch] = 10'(vin);
      wr(2'd1, {rj, 5'b0, 1'b1, 1'b0});
      wr(2'd0, c0(sel, ch, 0, 1));
      wr(2'd0, c0(sel, ch, 1, 1));
      cs = cyc;
      rd(2'd0, v);
      check(v[2] == 1'b1, "R3 busy after start", v[2], 1);
      check(dac_code == 10'h200, "R5 first trial is MSB", dac_code, 10'h200);
      check(chan_sel == 3'(ch), "R10 channel latched", chan_sel, ch);
      wait_idle(cs, d);
      check(d == 13 * ratio(sel), "R4 conversion length", d, 13 * ratio(sel));
      rd(2'd2, h); rd(2'd3, l);
      check(h == 8'(exp_hi(vin, rj)), "R5/R12 result high", h, exp_hi(vin, rj));
      check(l == 8'(exp_lo(vin, rj)), "R5/R12 result low", l, exp_lo(vin, rj));
      rd(2'd1, v);
      check(v[0] == 1'b1 && irq == 1'b1, "R13 flag and irq set", {v[0], irq}, 3);
    end

    // R12 format applies at read time (last result 0x1FF)
    wr(2'd1, 8'h01);
    rd(2'd2, h); rd(2'd3, l);
    check(h == 8'h7F && l == 8'hC0, "R12 reformat left", {h, l}, 16'h7FC0);
    rd(2'd1, v);
    check(v[0] == 1'b1 && irq == 1'b0, "R13 irq masked, write 1 keeps flag", {v[0], irq}, 2);
    wr(2'd1, 8'h82);
    rd(2'd1, v);
    check(v[0] == 1'b0 && irq == 1'b0, "R13 flag cleared", {v[0], irq}, 0);

    // R11 rewrites during a conversion
    ana[2] = 10'h0C3;
    wr(2'd0, c0(1, 2, 0, 1));
    wr(2'd0, c0(1, 2, 1, 1));
    cs = cyc;
    repeat (10) @(negedge clk);
    wr(2'd0, c0(2, 5, 1, 1));
    rd(2'd0, v);
    check(v[2] == 1'b1 && chan_sel == 3'd2, "R11 restart ignored, channel held", {v[2], chan_sel}, 4'hA);
    wr(2'd0, c0(2, 5, 0, 1));
    rd(2'd0, v);
    check(v[2] == 1'b1, "R11 write 0 to start bit while busy", v[2], 1);
    wait_idle(cs, d);
    check(d == 13 * 8, "R11 length unchanged by rewrite", d, 104);
    rd(2'd2, h); rd(2'd3, l);
    check({h, l} == 16'h00C3, "R11 result from latched channel", {h, l}, 16'h00C3);

    // R6/R8 cancel by clearing enable
    wr(2'd1, 8'h82);
    rd(2'd2, h); rd(2'd3, l);
    ana[4] = 10'h3C0;
    wr(2'd0, c0(1, 4, 0, 1));
    wr(2'd0, c0(1, 4, 1, 1));
    repeat (20) @(negedge clk);
    wr(2'd0, c0(1, 4, 0, 0));
    @(negedge clk);
    rd(2'd0, v);
    check(v[2] == 1'b0, "R6 clearing enable cancels", v[2], 0);
    rd(2'd2, h2); rd(2'd3, l2); rd(2'd1, v);
    check({h2, l2} == {h, l} && v[0] == 1'b0, "R8 cancel keeps result and flag", {h2, l2, v[0]}, {h, l, 1'b0});

    // R7/R8 sleep cancels a divided-clock conversion
    wr(2'd0, c0(2, 4, 0, 1));
    wr(2'd0, c0(2, 4, 1, 1));
    repeat (30) @(negedge clk);
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    rd(2'd0, v);
    check(v[2] == 1'b0 && v[0] == 1'b0, "R7 sleep cancels and disables", {v[2], v[0]}, 0);
    rd(2'd2, h2); rd(2'd3, l2); rd(2'd1, v);
    check({h2, l2} == {h, l} && v[0] == 1'b0, "R8 sleep cancel keeps result and flag", {h2, l2, v[0]}, {h, l, 1'b0});

    // R9/R7 RC source: startup delay, survives sleep
    rc_on = 1'b1;
    ana[4] = 10'h2E7;
    wr(2'd0, c0(3, 4, 0, 1));
    wr(2'd0, c0(3, 4, 1, 1));
    sleep_req = 1'b1;
    check(dac_code == 10'h000, "R9 no trial right after start", dac_code, 0);
    repeat (3) @(negedge clk);
    check(dac_code == 10'h000, "R9 no trial during delay", dac_code, 0);
    @(negedge clk);
    check(dac_code == 10'h200, "R9 trial after delay", dac_code, 10'h200);
    cs = cyc;
    wait_idle(cs, d);
    sleep_req = 1'b0;
    rc_on = 1'b0;
    check(d > 13 * 5 && d < 13 * 7, "R9 paced by rc ticks", d, 13 * 6);
    rd(2'd0, v);
    check(v[0] == 1'b1, "R7 RC conversion keeps enable under sleep", v[0], 1);
    rd(2'd2, h); rd(2'd3, l);
    check({h, l} == 16'h02E7, "R7/R9 RC result", {h, l}, 16'h02E7);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule